// File: doc/BRIEF.md
# Masked vector expand unit

The unit spreads the packed low elements of a source vector out to the destination positions selected by a mask. Destination positions are visited in ascending order. Each position whose mask bit is set takes the next unused source element, so the element that lands in position i is source element number popcount(mask[i-1:0]). The source index moves on only when a set position has taken an element.

Positions whose mask bit is clear either keep the matching element of a merge vector or are cleared to zero, as the mode input selects. Elements are 8-bit bytes or 16-bit words. The active vector length is 128, 256 or 512 bits, and every result bit above the active length is forced to zero. The packed source is supplied as a register value. A request is accepted when `in_valid` is high, and the result is registered one cycle later.

Top module: `vexpand_unit`

## Requirements
- R1: After reset deasserts, `out_valid` is 0 and `result` is all zeros, until the first accepted request.
- R2: A request with `in_valid` high sets `out_valid` high on the next clock edge and loads `result` on that same edge. `out_valid` is low after any edge where `in_valid` was low.
- R3: While `in_valid` is low, `result` keeps its value, whatever the data inputs do.
- R4: Each active destination element whose mask bit is set receives source element k, where k is the number of set mask bits below it. Source elements are counted from the low end of `src_vec`.
- R5: An active destination element whose mask bit is clear behaves as follows. With `zero_mode` at 0 it takes the same-position element of `merge_vec`. With `zero_mode` at 1 it is zero.
- R6: `elem_word` selects the element size.
  - At 0, elements are bytes, and mask bit j governs byte j (bits 8j+7..8j).
  - At 1, elements are 16-bit words, and mask bit i governs bytes 2i and 2i+1. The low byte of each word is the lower-addressed byte.
- R7: `vlen_sel` selects the active length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. All result bits at or above the active length are zero in both modes.
- R8: Mask bits at or above the active element count are ignored. The lanes they govern read zero, and the lanes below them are unaffected.
- R9: Source elements at or beyond the number of set active mask bits have no effect on the result.
- R10: With every active mask bit set, the result equals `src_vec` within the active length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept a request this cycle |
| src_vec | input | 512 | Packed source elements, low element first |
| merge_vec | input | 512 | Values kept in clear positions in merge mode |
| mask | input | 64 | Per-element fill mask (low 32 bits used in word mode) |
| elem_word | input | 1 | 0: byte elements, 1: 16-bit word elements |
| vlen_sel | input | 2 | Active length: 0=128, 1=256, 2/3=512 bits |
| zero_mode | input | 1 | 0: merge clear positions, 1: zero them |
| out_valid | output | 1 | Result was loaded on the last edge |
| result | output | 512 | Registered expanded vector |

## Verification
A wrong prefix count shows in the cycle after the request. Every set lane above the first miscounted position then carries a shifted source element, so one off-by-one usually corrupts a whole run of bytes rather than a single one. A wrong live-lane or word-pairing decision also appears on the next edge: nonzero bytes appear above the active length, or the two halves of a word come from different source words. Because the result is a single register stage, each bench check samples exactly one edge after the request and can attribute any error to that request alone.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

  typedef enum logic [1:0] {
    VL_128  = 2'd0,
    VL_256  = 2'd1,
    VL_512  = 2'd2,
    VL_512X = 2'd3
  } vlen_e;

  // Number of live bytes for a length code, capped at the datapath width.
  function automatic int live_bytes(input logic [1:0] code, input int lanes);
    int n;
    case (code)
      2'd0:    n = 16;
      2'd1:    n = 32;
      default: n = 64;
    endcase
    if (n > lanes) n = lanes;
    return n;
  endfunction

  // Number of live elements for a length code and element size.
  function automatic int live_elems(input logic [1:0] code, input logic word,
                                    input int lanes);
    int nb;
    nb = live_bytes(code, lanes);
    return word ? (nb / 2) : nb;
  endfunction

endpackage

// File: rtl/vexp_ctrl.sv
module vexp_ctrl #(
  parameter int LANES = 64,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic [LANES-1:0]           mask,
  input  logic                       elem_word,
  input  logic [1:0]                 vlen_sel,
  output logic [LANES-1:0]           lane_take,
  output logic [LANES-1:0]           lane_live,
  output logic [LANES-1:0][IDXW-1:0] lane_src
);
  logic [LANES-1:0]           elem_on;
  logic [LANES-1:0][IDXW-1:0] elem_pre;
  int                         n_bytes;
  int                         n_elems;

  // Element-level fill mask and exclusive prefix count of set bits.
  always_comb begin
    int run;
    n_bytes = vexp_pkg::live_bytes(vlen_sel, LANES);
    n_elems = vexp_pkg::live_elems(vlen_sel, elem_word, LANES);
    run = 0;
    for (int e = 0; e < LANES; e++) begin
      elem_on[e]  = mask[e] && (e < n_elems);
      elem_pre[e] = IDXW'(run);
      run = run + (elem_on[e] ? 1 : 0);
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int WE = j / 2;
    localparam logic HALF = 1'(j % 2);
    logic [IDXW-1:0] word_src;
    assign word_src     = {elem_pre[WE][IDXW-2:0], HALF};
    assign lane_live[j] = (j < n_bytes);
    assign lane_take[j] = elem_word ? elem_on[WE] : elem_on[j];
    assign lane_src[j]  = elem_word ? word_src : elem_pre[j];
  end

endmodule

// File: rtl/vexp_route.sv
module vexp_route #(
  parameter int LANES = 64,
  localparam int IDXW = $clog2(LANES),
  localparam int VBITS = LANES * 8
) (
  input  logic [VBITS-1:0]           src_vec,
  input  logic [VBITS-1:0]           merge_vec,
  input  logic                       zero_mode,
  input  logic [LANES-1:0]           lane_take,
  input  logic [LANES-1:0]           lane_live,
  input  logic [LANES-1:0][IDXW-1:0] lane_src,
  output logic [VBITS-1:0]           next_vec
);
  logic [LANES-1:0][7:0] src_b;
  logic [LANES-1:0][7:0] mrg_b;

  assign src_b = src_vec;
  assign mrg_b = merge_vec;

  for (genvar j = 0; j < LANES; j++) begin : g_mux
    always_comb begin
      if (!lane_live[j])
        next_vec[j*8 +: 8] = 8'h00;
      else if (lane_take[j])
        next_vec[j*8 +: 8] = src_b[lane_src[j]];
      else if (zero_mode)
        next_vec[j*8 +: 8] = 8'h00;
      else
        next_vec[j*8 +: 8] = mrg_b[j];
    end
  end

endmodule

// File: rtl/vexpand_unit.sv
module vexpand_unit #(
  parameter int VEC_BITS = 512,
  localparam int LANES = VEC_BITS / 8,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [VEC_BITS-1:0] src_vec,
  input  logic [VEC_BITS-1:0] merge_vec,
  input  logic [LANES-1:0]    mask,
  input  logic                elem_word,
  input  logic [1:0]          vlen_sel,
  input  logic                zero_mode,
  output logic                out_valid,
  output logic [VEC_BITS-1:0] result
);
  logic [LANES-1:0]           lane_take;
  logic [LANES-1:0]           lane_live;
  logic [LANES-1:0][IDXW-1:0] lane_src;
  logic [VEC_BITS-1:0]        next_vec;

  vexp_ctrl #(.LANES(LANES)) i_ctrl (
    .mask      (mask),
    .elem_word (elem_word),
    .vlen_sel  (vlen_sel),
    .lane_take (lane_take),
    .lane_live (lane_live),
    .lane_src  (lane_src)
  );

  vexp_route #(.LANES(LANES)) i_route (
    .src_vec   (src_vec),
    .merge_vec (merge_vec),
    .zero_mode (zero_mode),
    .lane_take (lane_take),
    .lane_live (lane_live),
    .lane_src  (lane_src),
    .next_vec  (next_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_vec;
    end
  end

  // Assertions
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));

  p_upper128_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen_sel == 2'd0) |=> (result[VEC_BITS-1:128] == '0));

  p_upper256_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen_sel == 2'd1) |=> (result[VEC_BITS-1:256] == '0));

  p_empty_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zero_mode && mask == '0) |=> (result == '0));

  p_empty_merge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zero_mode && mask == '0 && vlen_sel[1]) |=>
      (result == $past(merge_vec)));

  p_full_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vlen_sel[1] && !elem_word && (&mask)) |=>
      (result == $past(src_vec)));

endmodule

// File: tb/test_vexpand_unit.sv
module test_vexpand_unit;
  localparam int VB = 512;
  localparam int NL = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VB-1:0] src_vec = '0;
  logic [VB-1:0] merge_vec = '0;
  logic [NL-1:0] mask = '0;
  logic          elem_word = 1'b0;
  logic [1:0]    vlen_sel = 2'd0;
  logic          zero_mode = 1'b0;
  logic          out_valid;
  logic [VB-1:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  vexpand_unit #(.VEC_BITS(VB)) i_vexpand_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .merge_vec(merge_vec), .mask(mask), .elem_word(elem_word),
    .vlen_sel(vlen_sel), .zero_mode(zero_mode), .out_valid(out_valid),
    .result(result)
  );

  // Sequential walk: a read pointer into the source that steps per set element.
  function automatic logic [VB-1:0] model(input logic [VB-1:0] s,
      input logic [VB-1:0] m, input logic [NL-1:0] k, input logic w,
      input logic [1:0] vl, input logic z);
    logic [VB-1:0] r;
    int eb, nb, ne, rd;
    r  = '0;
    eb = w ? 2 : 1;
    nb = (vl == 2'd0) ? 16 : (vl == 2'd1) ? 32 : 64;
    ne = nb / eb;
    rd = 0;
    for (int e = 0; e < ne; e++) begin
      for (int b = 0; b < eb; b++) begin
        if (k[e])      r[(e*eb+b)*8 +: 8] = s[(rd*eb+b)*8 +: 8];
        else if (!z)   r[(e*eb+b)*8 +: 8] = m[(e*eb+b)*8 +: 8];
      end
      if (k[e]) rd++;
    end
    return r;
  endfunction

  function automatic logic [VB-1:0] rnd_vec();
    logic [VB-1:0] v;
    for (int i = 0; i < VB/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [VB-1:0] act,
                           input logic [VB-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // Drive at negedge, accept on next posedge, sample at the following negedge.
  task automatic run_op(input string tag, input logic [VB-1:0] s,
      input logic [VB-1:0] m, input logic [NL-1:0] k, input logic w,
      input logic [1:0] vl, input logic z);
    src_vec = s; merge_vec = m; mask = k; elem_word = w;
    vlen_sel = vl; zero_mode = z; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " R2 valid"}, out_valid, 1'b1);
    check_vec(tag, result, model(s, m, k, w, vl, z));
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VB-1:0] s, m, keep, s2;
    logic [NL-1:0] k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check_bit("R1 out_valid after reset", out_valid, 1'b0);
    check_vec("R1 result after reset", result, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 out_valid idle", out_valid, 1'b0);

    s = rnd_vec(); m = rnd_vec();
    // R4 byte expand, alternating mask, full length
    run_op("R4 byte alt", s, m, {32{2'b10}}, 1'b0, 2'd2, 1'b0);
    // R5 zero mode
    run_op("R5 zero mode", s, m, {32{2'b01}}, 1'b0, 2'd2, 1'b1);
    // R5 empty mask merge
    run_op("R5 empty merge", s, m, '0, 1'b0, 2'd2, 1'b0);
    // R6 word mode, sparse mask
    run_op("R6 word sparse", s, m, 64'h0000_0000_8421_0C03, 1'b1, 2'd2, 1'b0);
    // R6 word mode ignores mask bits 32..63
    run_op("R6 word high mask", s, m, 64'hFFFF_FFFF_0000_0011, 1'b1, 2'd3, 1'b1);
    // R7 length 128 and 256
    run_op("R7 len128", s, m, 64'h5A5A_5A5A_5A5A_5A5A, 1'b0, 2'd0, 1'b0);
    run_op("R7 len256", s, m, 64'h5A5A_5A5A_5A5A_5A5A, 1'b1, 2'd1, 1'b0);
    // R8 mask bits above active count ignored
    run_op("R8 high bits", s, m, 64'hFFFF_FFFF_FFFF_0003, 1'b0, 2'd0, 1'b0);
    keep = result;
    run_op("R8 high bits clear", s, m, 64'h0000_0000_0000_0003, 1'b0, 2'd0, 1'b0);
    check_vec("R8 compare", result, keep);
    // R10 all ones
    run_op("R10 all ones byte", s, m, '1, 1'b0, 2'd2, 1'b0);
    check_vec("R10 equals source", result, s);
    run_op("R10 all ones word256", s, m, '1, 1'b1, 2'd1, 1'b1);
    check_vec("R10 equals source256", result, {256'b0, s[255:0]});
    // R9 unused source elements: 3 set bits, change source above byte 3
    run_op("R9 base", s, m, 64'h8000_0100_0000_0001, 1'b0, 2'd2, 1'b1);
    keep = result;
    s2 = rnd_vec(); s2[23:0] = s[23:0];
    run_op("R9 altered", s2, m, 64'h8000_0100_0000_0001, 1'b0, 2'd2, 1'b1);
    check_vec("R9 compare", result, keep);

    // R3 hold while idle
    keep = result;
    src_vec = rnd_vec(); merge_vec = rnd_vec(); mask = '1; zero_mode = 1'b0;
    repeat (3) @(negedge clk);
    check_vec("R3 hold", result, keep);
    check_bit("R2 valid low", out_valid, 1'b0);

    // Random mix (R4 R5 R6 R7)
    for (int it = 0; it < 400; it++) begin
      s = rnd_vec(); m = rnd_vec();
      k = {$urandom, $urandom};
      if (it % 4 == 1) k = k & {$urandom, $urandom};
      if (it % 4 == 2) k = k | {$urandom, $urandom};
      run_op("R4 random", s, m, k, 1'($urandom), 2'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule